// File: doc/BRIEF.md
# Stack Address Window Decoder

This unit decides whether a physical address falls inside one of four programmable windows owned by a single bridge stack: two general memory-mapped windows, a window onto the stack's own register file and a window onto its interrupt space. Software programs the windows through a 64-bit register port addressed in bytes. The decoder then classifies each presented lookup address, one lookup per cycle, with one cycle of latency.

Each window has a base register. The two memory-mapped windows also have a mask register that sets their size. A single enable register switches the windows on and off. Every register keeps only its architecturally meaningful bits. The window base is the stored register moved down by eight bit positions. When windows overlap, a fixed priority picks one winner, and the unit reports the distance of the address from that winner's base. Rewriting the base or mask of a window that is switched on is allowed, but it raises a one-cycle error pulse.

Top module: `barwin_unit`

## Requirements
- R1: After reset every register reads as zero, every window is off, and no lookup reports a hit.
- R2: The register index is the byte address shifted right by 3. Index 0 is the enable register. Indices 1 and 2 are the first memory window's base and mask. Indices 3 and 4 are the second memory window's base and mask. Index 5 is the register window base and index 6 is the interrupt window base. A write to index 7 is ignored, and a read of it returns zero. `cfg_rvalid` rises one cycle after `cfg_rd`, carrying the register value from before any write in that same cycle.
- R3: Only 8-byte accesses (`cfg_size` = 3) take effect. A write of any other size leaves the register unchanged, and a read of any other size returns zero.
- R4: The enable register stores only bits 63:60. Bit 63 enables memory window 0, bit 62 memory window 1, bit 61 the register window and bit 60 the interrupt window.
- R5: The base and mask registers of both memory windows store bits 63:24 and read back zero below that.
- R6: The register window base stores bits 63:22. The interrupt window base stores bits 63:36.
- R7: A window's base is its stored base register shifted right by 8. A memory window spans (inverted mask >> 8) + 1 bytes. A window hits only when it is enabled and base <= address < base + span.
- R8: The register window spans REG_COUNT*8 bytes. The interrupt window spans INT_COUNT*65536 bytes.
- R9: `lk_hit` bit i flags window i, numbered 0 to 3 as memory window 0, memory window 1, register window and interrupt window. `lk_win` is one-hot on the lowest-numbered window that hits. `lk_offset` is the address minus that window's base. With no hit, both are zero.
- R10: A base or mask write while the owning window is enabled still updates the register, and `cfg_err` pulses high in the following cycle. Writes to other registers, and writes to windows that are off, never raise it.
- R11: Lookup results appear with `lk_done` one cycle after `lk_valid`. A lookup issued in the same cycle as a register write uses the register values from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_addr | input | 6 | Register byte address |
| cfg_size | input | 2 | Access size as log2 of bytes |
| cfg_wdata | input | 64 | Write data |
| cfg_rdata | output | 64 | Read data |
| cfg_rvalid | output | 1 | Read data valid |
| cfg_err | output | 1 | Live-window reprogramming pulse |
| lk_valid | input | 1 | Lookup strobe |
| lk_addr | input | 64 | Lookup physical address |
| lk_done | output | 1 | Lookup result valid |
| lk_hit | output | 4 | Raw hit per window |
| lk_win | output | 4 | One-hot winning window |
| lk_offset | output | 64 | Offset within winning window |

## Verification
A register write and an address lookup can land in the same cycle. The case that matters is a write that turns a window off while a lookup aims at that window. The bench drives both strobes on one edge. It expects the lookup to still hit on the old enable value, and the next lookup to the same address to miss. Base rewrites on live windows are also timed so that the error pulse and the readback of the new value are judged in consecutive cycles.

// File: rtl/barwin_pkg.sv
package barwin_pkg;
  localparam int NWIN      = 4;
  localparam int DW        = 64;
  localparam int IDX_W     = 3;
  localparam int CFG_AW    = IDX_W + 3;
  localparam int NREG      = 1 << IDX_W;
  localparam int BASE_SHIFT = 8;
  localparam logic [1:0] SIZE_DWORD = 2'd3;

  localparam logic [IDX_W-1:0] IX_ENABLE = 3'd0;
  localparam logic [IDX_W-1:0] IX_M0_BASE = 3'd1;
  localparam logic [IDX_W-1:0] IX_M0_MASK = 3'd2;
  localparam logic [IDX_W-1:0] IX_M1_BASE = 3'd3;
  localparam logic [IDX_W-1:0] IX_M1_MASK = 3'd4;
  localparam logic [IDX_W-1:0] IX_RW_BASE = 3'd5;
  localparam logic [IDX_W-1:0] IX_IW_BASE = 3'd6;

  localparam logic [DW-1:0] KEEP_EN   = 64'hF000_0000_0000_0000;
  localparam logic [DW-1:0] KEEP_MMIO = 64'hFFFF_FFFF_FF00_0000;
  localparam logic [DW-1:0] KEEP_RW   = 64'hFFFF_FFFF_FFC0_0000;
  localparam logic [DW-1:0] KEEP_IW   = 64'hFFFF_FFF0_0000_0000;

  typedef logic [NWIN-1:0][DW-1:0] win_vec_t;

  function automatic logic [DW-1:0] keep_for(input logic [IDX_W-1:0] idx);
    case (idx)
      IX_ENABLE:                                        return KEEP_EN;
      IX_M0_BASE, IX_M0_MASK, IX_M1_BASE, IX_M1_MASK:   return KEEP_MMIO;
      IX_RW_BASE:                                       return KEEP_RW;
      IX_IW_BASE:                                       return KEEP_IW;
      default:                                          return '0;
    endcase
  endfunction

  function automatic logic is_window_reg(input logic [IDX_W-1:0] idx);
    return (idx != IX_ENABLE) && (keep_for(idx) != '0);
  endfunction

  function automatic logic [1:0] owner_of(input logic [IDX_W-1:0] idx);
    case (idx)
      IX_M0_BASE, IX_M0_MASK: return 2'd0;
      IX_M1_BASE, IX_M1_MASK: return 2'd1;
      IX_RW_BASE:             return 2'd2;
      default:                return 2'd3;
    endcase
  endfunction

  function automatic logic [DW-1:0] win_base(input logic [DW-1:0] raw);
    return raw >> BASE_SHIFT;
  endfunction

  function automatic logic [DW-1:0] mmio_span(input logic [DW-1:0] mask);
    return ((~mask) >> BASE_SHIFT) + 64'd1;
  endfunction
endpackage

// File: rtl/barwin_cfg_regs.sv
module barwin_cfg_regs
  import barwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [1:0]        cfg_size,
  input  logic [DW-1:0]     cfg_wdata,
  output logic [DW-1:0]     cfg_rdata,
  output logic              cfg_rvalid,
  output logic              cfg_err,
  output logic [NWIN-1:0]   en_q,
  output win_vec_t          base_raw,
  output logic [1:0][DW-1:0] mask_raw
);
  logic [DW-1:0]    regs_q [NREG];
  logic [IDX_W-1:0] idx;
  logic             size_ok;
  logic             wr_ok;
  logic             rd_ok;
  logic [DW-1:0]    keep;
  logic             live_rewrite;

  assign idx     = cfg_addr[CFG_AW-1:3];
  assign size_ok = (cfg_size == SIZE_DWORD);
  assign wr_ok   = cfg_wr && size_ok;
  assign rd_ok   = cfg_rd && size_ok;
  assign keep    = keep_for(idx);
  assign live_rewrite = wr_ok && is_window_reg(idx) && en_q[owner_of(idx)];

  genvar gi;
  generate
    for (gi = 0; gi < NWIN; gi++) begin : g_en
      assign en_q[gi] = regs_q[IX_ENABLE][DW-1-gi];
    end
  endgenerate

  assign base_raw[0] = regs_q[IX_M0_BASE];
  assign base_raw[1] = regs_q[IX_M1_BASE];
  assign base_raw[2] = regs_q[IX_RW_BASE];
  assign base_raw[3] = regs_q[IX_IW_BASE];
  assign mask_raw[0] = regs_q[IX_M0_MASK];
  assign mask_raw[1] = regs_q[IX_M1_MASK];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
      cfg_rdata  <= '0;
      cfg_rvalid <= 1'b0;
      cfg_err    <= 1'b0;
    end else begin
      if (wr_ok && (keep != '0)) regs_q[idx] <= cfg_wdata & keep;
      cfg_err    <= live_rewrite;
      cfg_rvalid <= cfg_rd;
      cfg_rdata  <= rd_ok ? regs_q[idx] : '0;
    end
  end
endmodule

// File: rtl/barwin_match.sv
module barwin_match
  import barwin_pkg::*;
(
  input  logic          en,
  input  logic [DW-1:0] base,
  input  logic [DW-1:0] span,
  input  logic [DW-1:0] addr,
  output logic          hit,
  output logic [DW-1:0] offset
);
  logic above_base;
  assign above_base = (addr >= base);
  assign offset     = addr - base;
  assign hit        = en && above_base && (offset < span);
endmodule

// File: rtl/barwin_pick.sv
module barwin_pick
  import barwin_pkg::*;
(
  input  logic [NWIN-1:0] hit,
  input  win_vec_t        offs,
  output logic [NWIN-1:0] win,
  output logic [DW-1:0]   offset
);
  logic found;
  always_comb begin
    win    = '0;
    offset = '0;
    found  = 1'b0;
    for (int i = 0; i < NWIN; i++) begin
      if (!found && hit[i]) begin
        win[i] = 1'b1;
        offset = offs[i];
        found  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/barwin_unit.sv
module barwin_unit
  import barwin_pkg::*;
#(
  parameter int REG_COUNT = 1024,
  parameter int INT_COUNT = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [1:0]        cfg_size,
  input  logic [DW-1:0]     cfg_wdata,
  output logic [DW-1:0]     cfg_rdata,
  output logic              cfg_rvalid,
  output logic              cfg_err,
  input  logic              lk_valid,
  input  logic [DW-1:0]     lk_addr,
  output logic              lk_done,
  output logic [NWIN-1:0]   lk_hit,
  output logic [NWIN-1:0]   lk_win,
  output logic [DW-1:0]     lk_offset
);
  localparam logic [DW-1:0] REG_SPAN = 64'(REG_COUNT) * 64'd8;
  localparam logic [DW-1:0] INT_SPAN = 64'(INT_COUNT) << 16;

  logic [NWIN-1:0]    en_q;
  win_vec_t           base_raw;
  logic [1:0][DW-1:0] mask_raw;
  win_vec_t           base_w;
  win_vec_t           span_w;
  win_vec_t           off_w;
  logic [NWIN-1:0]    hit_w;
  logic [NWIN-1:0]    win_w;
  logic [DW-1:0]      off_sel;

  barwin_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_size(cfg_size), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid), .cfg_err(cfg_err),
    .en_q(en_q), .base_raw(base_raw), .mask_raw(mask_raw)
  );

  genvar gw;
  generate
    for (gw = 0; gw < NWIN; gw++) begin : g_win
      assign base_w[gw] = win_base(base_raw[gw]);
      if (gw < 2) begin : g_mmio
        assign span_w[gw] = mmio_span(mask_raw[gw]);
      end else if (gw == 2) begin : g_regs
        assign span_w[gw] = REG_SPAN;
      end else begin : g_intr
        assign span_w[gw] = INT_SPAN;
      end
      barwin_match u_match (
        .en(en_q[gw]), .base(base_w[gw]), .span(span_w[gw]),
        .addr(lk_addr), .hit(hit_w[gw]), .offset(off_w[gw])
      );
    end
  endgenerate

  barwin_pick u_pick (.hit(hit_w), .offs(off_w), .win(win_w), .offset(off_sel));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk_done   <= 1'b0;
      lk_hit    <= '0;
      lk_win    <= '0;
      lk_offset <= '0;
    end else begin
      lk_done   <= lk_valid;
      lk_hit    <= lk_valid ? hit_w   : '0;
      lk_win    <= lk_valid ? win_w   : '0;
      lk_offset <= lk_valid ? off_sel : '0;
    end
  end
endmodule

// File: rtl/barwin_checker.sv
module barwin_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_wr,
  input logic       cfg_rd,
  input logic       cfg_rvalid,
  input logic       cfg_err,
  input logic       lk_valid,
  input logic       lk_done,
  input logic [3:0] lk_hit,
  input logic [3:0] lk_win,
  input logic [3:0] en_q
);
  assert_win_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lk_done |-> $onehot0(lk_win));
  assert_win_subset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lk_done |-> ((lk_win & ~lk_hit) == 4'b0));
  assert_first_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_done && lk_hit[0]) |-> lk_win[0]);
  assert_hit_has_winner_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_done && (lk_hit != 4'b0)) |-> (lk_win != 4'b0));
  assert_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> lk_done);
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_done |-> (lk_hit == 4'b0));
  assert_enable_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lk_done |-> ((lk_hit & ~$past(en_q)) == 4'b0));
  assert_err_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> ($past(cfg_wr) && ($past(en_q) != 4'b0)));
  assert_rvalid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rvalid |-> $past(cfg_rd));
endmodule

bind barwin_unit barwin_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
  .cfg_rvalid(cfg_rvalid), .cfg_err(cfg_err), .lk_valid(lk_valid),
  .lk_done(lk_done), .lk_hit(lk_hit), .lk_win(lk_win), .en_q(en_q)
);

// File: tb/tb_barwin_unit.sv
module tb_barwin_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [1:0]  cfg_size = 2'd3;
  logic [63:0] cfg_wdata = '0;
  logic [63:0] cfg_rdata;
  logic        cfg_rvalid, cfg_err;
  logic        lk_valid = 1'b0;
  logic [63:0] lk_addr = '0;
  logic        lk_done;
  logic [3:0]  lk_hit, lk_win;
  logic [63:0] lk_offset;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  barwin_unit dut (.*);

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [63:0] d, input logic [1:0] sz,
                    input logic exp_err, input string tag);
    @(negedge clk);
    cfg_wr = 1; cfg_addr = 6'(idx << 3); cfg_size = sz; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0; cfg_size = 2'd3;
    chk(tag, {63'd0, cfg_err}, {63'd0, exp_err});
  endtask

  task automatic rd(input int idx, input logic [1:0] sz, input logic [63:0] exp, input string tag);
    @(negedge clk);
    cfg_rd = 1; cfg_addr = 6'(idx << 3); cfg_size = sz;
    @(negedge clk);
    cfg_rd = 0; cfg_size = 2'd3;
    chk({tag, " rvalid"}, {63'd0, cfg_rvalid}, 64'd1);
    chk(tag, cfg_rdata, exp);
  endtask

  task automatic look(input logic [63:0] a, input logic [3:0] ehit, input logic [3:0] ewin,
                      input logic [63:0] eoff, input string tag);
    @(negedge clk);
    lk_valid = 1; lk_addr = a;
    @(negedge clk);
    lk_valid = 0;
    chk({tag, " done"}, {63'd0, lk_done}, 64'd1);
    chk({tag, " hit"}, {60'd0, lk_hit}, {60'd0, ehit});
    chk({tag, " win"}, {60'd0, lk_win}, {60'd0, ewin});
    chk({tag, " off"}, lk_offset, eoff);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 8; i++) rd(i, 2'd3, 64'd0, "R1 reset read");
    look(64'd0, 4'b0, 4'b0, 64'd0, "R1 reset lookup");
  endtask

  task automatic t_masks;
    wr(1, '1, 2'd3, 0, "R5 m0 base err");
    wr(2, '1, 2'd3, 0, "R5 m0 mask err");
    wr(3, '1, 2'd3, 0, "R5 m1 base err");
    wr(4, '1, 2'd3, 0, "R5 m1 mask err");
    wr(5, '1, 2'd3, 0, "R6 rw base err");
    wr(6, '1, 2'd3, 0, "R6 iw base err");
    wr(7, '1, 2'd3, 0, "R2 idx7 err");
    rd(1, 2'd3, 64'hFFFF_FFFF_FF00_0000, "R5 m0 base keep");
    rd(2, 2'd3, 64'hFFFF_FFFF_FF00_0000, "R5 m0 mask keep");
    rd(3, 2'd3, 64'hFFFF_FFFF_FF00_0000, "R5 m1 base keep");
    rd(4, 2'd3, 64'hFFFF_FFFF_FF00_0000, "R5 m1 mask keep");
    rd(5, 2'd3, 64'hFFFF_FFFF_FFC0_0000, "R6 rw base keep");
    rd(6, 2'd3, 64'hFFFF_FFF0_0000_0000, "R6 iw base keep");
    rd(7, 2'd3, 64'd0, "R2 idx7 ignored");
    wr(0, '1, 2'd3, 0, "R4 enable err");
    rd(0, 2'd3, 64'hF000_0000_0000_0000, "R4 enable keep");
    wr(0, 64'd0, 2'd3, 0, "R4 enable clear");
  endtask

  task automatic t_size;
    wr(1, 64'd0, 2'd2, 0, "R3 short write");
    rd(1, 2'd3, 64'hFFFF_FFFF_FF00_0000, "R3 short write ignored");
    rd(1, 2'd1, 64'd0, "R3 short read zero");
  endtask

  task automatic t_mmio;
    wr(1, 64'h0000_0012_3400_0000, 2'd3, 0, "R7 m0 base");
    wr(2, 64'hFFFF_FFFF_FF00_0000, 2'd3, 0, "R7 m0 mask");
    look(64'h1234_0000, 4'b0, 4'b0, 64'd0, "R7 disabled miss");
    wr(0, 64'h8000_0000_0000_0000, 2'd3, 0, "R7 enable m0");
    look(64'h1234_0000, 4'b0001, 4'b0001, 64'd0, "R7 base hit");
    look(64'h1234_FFFF, 4'b0001, 4'b0001, 64'hFFFF, "R7 last byte hit");
    look(64'h1235_0000, 4'b0, 4'b0, 64'd0, "R7 end miss");
    look(64'h1233_FFFF, 4'b0, 4'b0, 64'd0, "R7 below miss");
  endtask

  task automatic t_fixed;
    wr(5, 64'h0000_0100_0000_0000, 2'd3, 0, "R8 rw base");
    wr(6, 64'h0000_0010_0000_0000, 2'd3, 0, "R8 iw base");
    wr(0, 64'hB000_0000_0000_0000, 2'd3, 0, "R8 enable");
    look(64'h1_0000_1FF8, 4'b0100, 4'b0100, 64'h1FF8, "R8 rw last");
    look(64'h1_0000_2000, 4'b0, 4'b0, 64'd0, "R8 rw end");
    look(64'h10FF_FFFF, 4'b1000, 4'b1000, 64'hFF_FFFF, "R8 iw last");
    look(64'h1100_0000, 4'b0, 4'b0, 64'd0, "R8 iw end");
  endtask

  task automatic t_prio;
    wr(3, 64'h0000_0010_0000_0000, 2'd3, 0, "R9 m1 base");
    wr(4, 64'd0, 2'd3, 0, "R9 m1 mask");
    wr(0, 64'hF000_0000_0000_0000, 2'd3, 0, "R9 enable all");
    look(64'h1000_0010, 4'b1010, 4'b0010, 64'h10, "R9 m1 over iw");
    look(64'h1234_0004, 4'b0011, 4'b0001, 64'h4, "R9 m0 over m1");
    look(64'h1_0000_0008, 4'b0110, 4'b0010, 64'hF000_0008, "R9 m1 over rw");
  endtask

  task automatic t_err;
    wr(1, 64'h0000_0056_7800_0000, 2'd3, 1, "R10 live m0 base");
    rd(1, 2'd3, 64'h0000_0056_7800_0000, "R10 live base updated");
    wr(1, 64'h0000_0012_3400_0000, 2'd3, 1, "R10 live m0 base back");
    wr(4, 64'd0, 2'd3, 1, "R10 live m1 mask");
    wr(5, 64'h0000_0100_0000_0000, 2'd3, 1, "R10 live rw base");
    wr(6, 64'h0000_0010_0000_0000, 2'd3, 1, "R10 live iw base");
    wr(0, 64'h8000_0000_0000_0000, 2'd3, 0, "R10 enable no err");
    wr(5, 64'h0000_0100_0000_0000, 2'd3, 0, "R10 off window no err");
    wr(7, 64'hFFFF, 2'd3, 0, "R10 idx7 no err");
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    cfg_wr = 1; cfg_addr = 6'd0; cfg_wdata = 64'd0; cfg_size = 2'd3;
    lk_valid = 1; lk_addr = 64'h1234_0020;
    @(negedge clk);
    cfg_wr = 0; lk_valid = 0;
    chk("R11 same-cycle hit", {60'd0, lk_win}, 64'b0001);
    chk("R11 same-cycle off", lk_offset, 64'h20);
    look(64'h1234_0020, 4'b0, 4'b0, 64'd0, "R11 after disable miss");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_masks();
    t_size();
    t_mmio();
    t_fixed();
    t_prio();
    t_err();
    t_same_cycle();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule